// File: doc/BRIEF.md
# Receive Wake-Up Calibration Sequencer

This block runs the receive path's power-up sequence each time the path leaves sleep. Time is counted in symbols of 48 master-clock cycles. The sequence has four phases in a fixed order:

1. A fixed settle interval.
2. A programmable delay.
3. An optional offset-calibration window.
4. A second programmable delay.

When the last phase ends, the block raises a data-valid flag. That flag stays high for as long as the path remains enabled.

During the calibration window the block drives two controls:

- **Input-short control.** It asks the analog front end to short its inputs, but only when internal calibration is chosen. It releases the short well before the window ends, so the front end and filter can settle again.
- **Averaging-enable.** It is sent to the offset accumulator and stays high for exactly sixteen sample strobes at the start of the window.

Calibration is skipped entirely when automatic calibration is off. If the enable drops at any time, the sequence aborts.

Top module: `rx_wake_sequencer`

## Requirements
- R1: The path is enabled while `en_pin` OR `en_bit` is high. Enabling from idle starts the sequence with the settle phase on the next clock edge.
- R2: The settle phase lasts exactly 36 × 48 = 1728 clock cycles.
- R3: The first delay phase lasts `dly_pre` × 48 cycles. A value of 0 makes it last exactly one cycle.
- R4: With `autocal_en` = 1, a calibration phase of 40 × 48 = 1920 cycles follows the first delay. With `autocal_en` = 0, no cycles are spent on calibration.
- R5: With `cal_external` = 0, `in_short` is high for exactly the first 32 symbols (1536 cycles) of the calibration phase. With `cal_external` = 1, it never rises.
- R6: `avg_en` goes high at the start of the calibration phase. It stays high until exactly 16 cycles with `sample_stb` high have been seen, and is never high outside calibration.
- R7: The second delay phase lasts `dly_post` × 48 cycles, or one cycle for 0. `data_valid` then goes high and stays high while enabled. With enable applied before clock edge 0, `data_valid` first reads 1 after edge 1728 + d1 + c + d2, where:
  - d1 is the first delay length in cycles per R3;
  - c is 1920 or 0 per R4;
  - d2 is the second delay length in cycles per R7.
- R8: When enable is low at a clock edge, that edge returns the block to idle. `data_valid`, `in_short` and `avg_en` are then low. A later enable restarts the whole sequence from settle.
- R9: After reset, `data_valid`, `in_short` and `avg_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Receive enable from the pin |
| en_bit | input | 1 | Receive enable from the control register |
| autocal_en | input | 1 | 1 = run calibration during wake-up |
| cal_external | input | 1 | 1 = calibrate with inputs left connected |
| dly_pre | input | 8 | Pre-calibration delay in symbols |
| dly_post | input | 8 | Post-calibration delay in symbols |
| sample_stb | input | 1 | One-cycle strobe per filter output sample |
| in_short | output | 1 | Request to short the receive inputs |
| avg_en | output | 1 | Averaging enable to the offset accumulator |
| data_valid | output | 1 | Receive output words are valid |

## Verification
The bench measures the exact cycle at which `data_valid` rises for several combinations of delays, calibration on or off, and calibration mode. A zero delay that is counted as 256 symbols, or as zero cycles, would show up as a latency error of many symbols or of one cycle.

Over each run, the bench also counts the cycles with `in_short` high and the strobes seen while `avg_en` is high. Two faults would appear as wrong totals:

- a short that is not released early, or is applied in external mode;
- averaging that stops at 15 or 17 samples.

Finally, the bench aborts the sequence both in the middle of calibration and after data is valid, then re-enables. A design that kept its counters across the abort, or held its outputs high after the abort, would fail there.

// File: rtl/rx_wake_sequencer.sv
module rx_wake_sequencer #(
  parameter int SYM_CLKS      = 48,
  parameter int SETTLE_SYMS   = 36,
  parameter int CAL_SYMS      = 40,
  parameter int RESETTLE_SYMS = 8,
  parameter int AVG_SAMPLES   = 16,
  parameter int DLY_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_pin,
  input  logic             en_bit,
  input  logic             autocal_en,
  input  logic             cal_external,
  input  logic [DLY_W-1:0] dly_pre,
  input  logic [DLY_W-1:0] dly_post,
  input  logic             sample_stb,
  output logic             in_short,
  output logic             avg_en,
  output logic             data_valid
);
  localparam int TW       = $clog2(SYM_CLKS);
  localparam int SW       = (DLY_W > 7) ? DLY_W + 1 : 8;
  localparam int ISO_SYMS = CAL_SYMS - RESETTLE_SYMS;
  localparam int AW       = $clog2(AVG_SAMPLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_PRE, S_CAL, S_POST, S_RUN} st_t;

  st_t           st, st_nx;
  logic [TW-1:0] tick;
  logic [SW-1:0] sym, len;
  logic [AW-1:0] avg_cnt;

  wire en      = en_pin | en_bit;
  wire sym_end = (tick == TW'(SYM_CLKS - 1));
  wire timed   = (st == S_SETTLE) || (st == S_PRE) || (st == S_CAL) || (st == S_POST);

  always_comb begin
    case (st)
      S_SETTLE: len = SW'(SETTLE_SYMS);
      S_PRE:    len = SW'(dly_pre);
      S_CAL:    len = SW'(CAL_SYMS);
      S_POST:   len = SW'(dly_post);
      default:  len = '0;
    endcase
  end

  wire last = timed && ((len == '0) || (sym_end && (SW'(sym + 1'b1) == len)));

  always_comb begin
    st_nx = st;
    if (!en) st_nx = S_IDLE;
    else begin
      case (st)
        S_IDLE:   st_nx = S_SETTLE;
        S_SETTLE: if (last) st_nx = S_PRE;
        S_PRE:    if (last) st_nx = autocal_en ? S_CAL : S_POST;
        S_CAL:    if (last) st_nx = S_POST;
        S_POST:   if (last) st_nx = S_RUN;
        default:  st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tick <= '0;
      sym  <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st) begin
        tick <= '0;
        sym  <= '0;
      end else if (timed) begin
        if (sym_end) begin
          tick <= '0;
          sym  <= sym + 1'b1;
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  avg_cnt <= '0;
    else if (st != S_CAL)        avg_cnt <= '0;
    else if (avg_en && sample_stb) avg_cnt <= avg_cnt + 1'b1;
  end

  wire iso_win = (st == S_CAL) && (sym < SW'(ISO_SYMS));

  assign in_short   = iso_win && !cal_external;
  assign avg_en     = iso_win && (avg_cnt < AW'(AVG_SAMPLES));
  assign data_valid = (st == S_RUN);

  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_pin || en_bit) |=> !data_valid && !in_short && !avg_en);

  assert_avg_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    avg_cnt <= AW'(AVG_SAMPLES));

  assert_short_not_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_short |-> !data_valid && !cal_external);

  assert_avg_not_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    avg_en |-> !data_valid);

  assert_valid_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(en_pin || en_bit));
endmodule

// File: tb/rx_wake_sequencer_test.sv
module rx_wake_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 1'b0, en_bit = 1'b0, autocal_en = 1'b0, cal_external = 1'b0;
  logic [7:0] dly_pre = '0, dly_post = '0;
  logic sample_stb = 1'b0;
  logic in_short, avg_en, data_valid;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  rx_wake_sequencer uut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_bit(en_bit),
    .autocal_en(autocal_en), .cal_external(cal_external),
    .dly_pre(dly_pre), .dly_post(dly_post), .sample_stb(sample_stb),
    .in_short(in_short), .avg_en(avg_en), .data_valid(data_valid));

  always @(negedge clk) begin
    cyc++;
    sample_stb <= (cyc % 4 == 0);
  end

  // {pin, bit, autocal, external, dly_pre[8], dly_post[8]}
  localparam logic [19:0] VEC [6] = '{
    {4'b1010, 8'd2, 8'd3},
    {4'b0111, 8'd0, 8'd1},
    {4'b1100, 8'd1, 8'd0},
    {4'b0101, 8'd0, 8'd0},
    {4'b1010, 8'd5, 8'd0},
    {4'b0110, 8'd0, 8'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dlen(input int n);
    return (n == 0) ? 1 : n * 48;
  endfunction

  task automatic run_vec(input logic [19:0] v, input string tag);
    int lat, first, shorts, avgs;
    lat = 1728 + dlen(int'(v[15:8])) + (v[17] ? 1920 : 0) + dlen(int'(v[7:0]));
    @(negedge clk);
    en_pin = v[19]; en_bit = v[18]; autocal_en = v[17]; cal_external = v[16];
    dly_pre = v[15:8]; dly_post = v[7:0];
    first = 0; shorts = 0; avgs = 0;
    for (int n = 1; n <= lat + 1; n++) begin
      @(negedge clk);
      #1;
      if (data_valid && first == 0) first = n;
      if (in_short) shorts++;
      if (avg_en && sample_stb) avgs++;
    end
    // R1 R2 R3 R4 R7: latency
    check({tag, " R7 latency"}, first, lat + 1);
    check({tag, " R5 short cycles"}, shorts, (v[17] && !v[16]) ? 1536 : 0);
    check({tag, " R6 avg strobes"}, avgs, v[17] ? 16 : 0);
  endtask

  task automatic drop_en;
    @(negedge clk);
    en_pin = 1'b0; en_bit = 1'b0;
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9 valid at reset", data_valid, 0);
    check("R9 short at reset", in_short, 0);
    check("R9 avg at reset", avg_en, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) begin
      run_vec(VEC[i], $sformatf("vec%0d", i));
      repeat (20) @(negedge clk);
      #1;
      check("R7 valid held", data_valid, 1);
      drop_en();
      check("R8 valid cleared", data_valid, 0);
    end

    // abort in middle of internal calibration
    @(negedge clk);
    en_pin = 1'b1; autocal_en = 1'b1; cal_external = 1'b0; dly_pre = 8'd1; dly_post = 8'd0;
    repeat (1728 + 48 + 200) @(negedge clk);
    #1;
    check("R5 short mid cal", in_short, 1);
    drop_en();
    check("R8 short cleared", in_short, 0);
    check("R8 avg cleared", avg_en, 0);

    // restart gives full latency again
    run_vec(VEC[3], "restart R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule